// File: doc/BRIEF.md
# Single-Bit Operation Unit

This unit carries out one single-bit operation on an 8-bit operand per cycle. The bit is chosen by an index, and the operation is picked by a 4-bit operation code. It sets, clears, inverts or tests the chosen bit. It can also move the bit to or from the carry flag. With the carry-logic operations, the carry flag works as a one-bit accumulator that is combined with the chosen bit by AND, OR or XOR. Every operation that reads the bit into the carry has a form that uses the complement of the bit.

The unit sits beside an execution datapath. The caller presents the operand byte, the index, the operation code and the present carry flag, together with a valid strobe. One cycle later the unit returns a registered result:
- the byte to write back, with a write enable;
- a new carry value, with its own enable;
- a new zero flag value, with its own enable.

Fetching or storing the operand in memory is left to the caller.

Top module: `bitop_unit`

## Requirements
- R1: While reset is held, and after it is released with no request, every output is 0.
- R2: A request accepted on `in_valid` at a clock edge produces `out_valid` high after that edge. An edge with `in_valid` low produces `out_valid` low.
- R3: Codes 0 (set), 1 (clear) and 2 (invert) modify only the bit selected by the mask `1 << index`. They return the modified byte with `out_wb` high and update no flag.
- R4: Code 3 (test) raises `out_z_we`. It drives `out_z` to 1 when the selected bit is 0 and to 0 when it is 1. It does not write back, and `out_byte` equals the input byte.
- R5: Code 4 (load) copies the selected bit into carry. Code 5 (inverted load) copies its complement. Both raise `out_c_we` and do not write back.
- R6: Code 6 (store) writes the incoming carry into the selected bit. Code 7 (inverted store) writes the complement of the carry. Both raise `out_wb`, leave the other bits unchanged and update no flag.
- R7: The codes for the carry-logic operations are 8 AND, 10 OR and 12 XOR, and 9, 11 and 13 for their inverted forms. Each combines the selected bit (or, in the inverted forms, its complement) with the incoming carry. It places the result on `out_c` with `out_c_we` high and does not write back.
- R8: Only the low three bits of the 4-bit index choose the bit. Index values 8 to 15 act exactly like their values minus 8.
- R9: Codes 14 and 15 have no effect. No enable is raised, and `out_byte` equals the input byte.
- R10: When `out_valid` is low, `out_wb`, `out_c_we` and `out_z_we` are low. A flag output whose enable is low reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_byte | input | 8 | Operand byte |
| in_idx | input | 4 | Bit index (low three bits used) |
| in_c | input | 1 | Present carry flag |
| out_valid | output | 1 | Result valid |
| out_byte | output | 8 | Resulting byte |
| out_wb | output | 1 | Byte write-back enable |
| out_c_we | output | 1 | Carry update enable |
| out_c | output | 1 | New carry value |
| out_z_we | output | 1 | Zero flag update enable |
| out_z | output | 1 | New zero flag value |

## Verification
Every operation code is driven with all 16 index values, both carry values and 16 operand bytes. The byte set includes all-zeros, all-ones and alternating patterns, so each chosen bit is seen both as 0 and as 1 against neighbours of either value. Sweeping both carry values separates the plain forms of the store and logic operations from their inverted forms. The upper half of the index range shows whether index bit 3 leaks into the mask. Idle cycles between bursts show whether the enables drop when no request is present.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [3:0] {
    OP_SET  = 4'd0,  OP_CLR  = 4'd1,  OP_INV  = 4'd2,  OP_TST  = 4'd3,
    OP_LD   = 4'd4,  OP_ILD  = 4'd5,  OP_ST   = 4'd6,  OP_IST  = 4'd7,
    OP_AND  = 4'd8,  OP_IAND = 4'd9,  OP_OR   = 4'd10, OP_IOR  = 4'd11,
    OP_XOR  = 4'd12, OP_IXOR = 4'd13, OP_RSV0 = 4'd14, OP_RSV1 = 4'd15
  } bitop_e;

  typedef struct packed {
    logic wb;
    logic c_we;
    logic c_val;
    logic z_we;
    logic z_val;
  } effect_t;

  // Carry combination: kind 0 AND, 1 OR, 2 XOR
  function automatic logic carry_combine(input logic [1:0] kind, input logic lit, input logic c);
    case (kind)
      2'd0:    carry_combine = lit & c;
      2'd1:    carry_combine = lit | c;
      default: carry_combine = lit ^ c;
    endcase
  endfunction
endpackage

// File: rtl/bitop_select.sv
module bitop_select #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              bit_o
);
  localparam int SEL_W = $clog2(DATA_W);

  logic [SEL_W-1:0] sel;
  assign sel = idx_i[SEL_W-1:0];

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask_o[g] = (sel == SEL_W'(g));
  end

  assign bit_o = |(byte_i & mask_o);
endmodule

// File: rtl/bitop_core.sv
module bitop_core
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  bitop_e            op_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              bit_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] byte_o,
  output effect_t           eff_o
);
  logic inv_form;
  logic lit;
  logic store_val;
  assign inv_form  = op_i[0];
  assign lit       = bit_i ^ inv_form;
  assign store_val = c_i ^ inv_form;

  always_comb begin
    byte_o = byte_i;
    eff_o  = '0;
    unique case (op_i)
      OP_SET: begin byte_o = byte_i | mask_i;  eff_o.wb = 1'b1; end
      OP_CLR: begin byte_o = byte_i & ~mask_i; eff_o.wb = 1'b1; end
      OP_INV: begin byte_o = byte_i ^ mask_i;  eff_o.wb = 1'b1; end
      OP_TST: begin eff_o.z_we = 1'b1; eff_o.z_val = ~bit_i; end
      OP_LD, OP_ILD: begin eff_o.c_we = 1'b1; eff_o.c_val = lit; end
      OP_ST, OP_IST: begin
        byte_o   = (byte_i & ~mask_i) | (store_val ? mask_i : '0);
        eff_o.wb = 1'b1;
      end
      OP_AND, OP_IAND: begin eff_o.c_we = 1'b1; eff_o.c_val = carry_combine(2'd0, lit, c_i); end
      OP_OR,  OP_IOR:  begin eff_o.c_we = 1'b1; eff_o.c_val = carry_combine(2'd1, lit, c_i); end
      OP_XOR, OP_IXOR: begin eff_o.c_we = 1'b1; eff_o.c_val = carry_combine(2'd2, lit, c_i); end
      default: ;
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_byte,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic              in_c,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_wb,
  output logic              out_c_we,
  output logic              out_c,
  output logic              out_z_we,
  output logic              out_z
);
  logic [DATA_W-1:0] sel_mask;
  logic              sel_bit;
  logic [DATA_W-1:0] core_byte;
  effect_t           core_eff;

  bitop_select #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel (
    .byte_i(in_byte), .idx_i(in_idx), .mask_o(sel_mask), .bit_o(sel_bit)
  );

  bitop_core #(.DATA_W(DATA_W)) u_core (
    .op_i(bitop_e'(in_op)), .byte_i(in_byte), .mask_i(sel_mask), .bit_i(sel_bit),
    .c_i(in_c), .byte_o(core_byte), .eff_o(core_eff)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !in_valid) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_wb    <= 1'b0;
      out_c_we  <= 1'b0;
      out_c     <= 1'b0;
      out_z_we  <= 1'b0;
      out_z     <= 1'b0;
    end else begin
      out_valid <= 1'b1;
      out_byte  <= core_byte;
      out_wb    <= core_eff.wb;
      out_c_we  <= core_eff.c_we;
      out_c     <= core_eff.c_val;
      out_z_we  <= core_eff.z_we;
      out_z     <= core_eff.z_val;
    end
  end

  // R2: result strobe tracks the request strobe by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10: no enable without a result
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_wb || out_c_we || out_z_we));
  // R3: at most one result kind per operation
  a_r3_single_effect: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_wb, out_c_we, out_z_we}));
  // R3: a write-back touches at most one bit of the operand
  a_r3_one_bit_touched: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!out_wb || $countones(out_byte ^ $past(in_byte)) <= 1));
  // R9: reserved codes raise nothing
  a_r9_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op >= 4'd14) |=> !(out_wb || out_c_we || out_z_we));
endmodule

// File: tb/bitop_unit_test.sv
module bitop_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_op = '0;
  logic [7:0] in_byte = '0;
  logic [3:0] in_idx = '0;
  logic       in_c = 1'b0;
  logic       out_valid, out_wb, out_c_we, out_c, out_z_we, out_z;
  logic [7:0] out_byte;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitop_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_byte(in_byte), .in_idx(in_idx), .in_c(in_c),
    .out_valid(out_valid), .out_byte(out_byte), .out_wb(out_wb),
    .out_c_we(out_c_we), .out_c(out_c), .out_z_we(out_z_we), .out_z(out_z)
  );

  function automatic logic [13:0] pack_out();
    return {out_valid, out_byte, out_wb, out_c_we, out_c, out_z_we, out_z};
  endfunction

  task automatic check(input string req, input logic [13:0] got, input logic [13:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%0d idx=%0d byte=%02h c=%0d: got %04h expected %04h",
               req, in_op, in_idx, in_byte, in_c, got, exp);
    end
  endtask

  function automatic string tag_of(input int op, input int idx);
    string t;
    if (op <= 2)       t = "R3";
    else if (op == 3)  t = "R4";
    else if (op <= 5)  t = "R5";
    else if (op <= 7)  t = "R6";
    else if (op <= 13) t = "R7";
    else               t = "R9";
    if (idx >= 8) t = {"R8 / ", t};
    return t;
  endfunction

  // Arithmetic reference: bit k weight is 2**k
  function automatic logic [13:0] model(input int op, input int b, input int idx, input int c);
    int k, w, bitv, inv, nb, wb, cwe, cv, zwe, zv, lit;
    k = idx % 8;
    w = 1 << k;
    bitv = (b / w) % 2;
    inv = op % 2;
    lit = (bitv + inv) % 2;
    nb = b; wb = 0; cwe = 0; cv = 0; zwe = 0; zv = 0;
    case (op)
      0: begin nb = bitv ? b : b + w; wb = 1; end
      1: begin nb = bitv ? b - w : b; wb = 1; end
      2: begin nb = bitv ? b - w : b + w; wb = 1; end
      3: begin zwe = 1; zv = 1 - bitv; end
      4, 5: begin cwe = 1; cv = lit; end
      6, 7: begin nb = b - bitv * w + ((c + inv) % 2) * w; wb = 1; end
      8, 9:   begin cwe = 1; cv = lit * c; end
      10, 11: begin cwe = 1; cv = (lit + c) > 0 ? 1 : 0; end
      12, 13: begin cwe = 1; cv = (lit + c) % 2; end
      default: ;
    endcase
    return {1'b1, 8'(nb), 1'(wb), 1'(cwe), 1'(cv), 1'(zwe), 1'(zv)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", pack_out(), 14'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", pack_out(), 14'h0);

    for (int op = 0; op < 16; op++) begin
      for (int bi = 0; bi < 16; bi++) begin
        int b;
        b = (bi == 0) ? 8'h00 : (bi == 1) ? 8'hFF : (bi == 2) ? 8'h55 :
            (bi == 3) ? 8'hAA : ((bi * 73 + 5) % 256);
        for (int idx = 0; idx < 16; idx++) begin
          for (int c = 0; c < 2; c++) begin
            in_valid = 1'b1;
            in_op = 4'(op); in_byte = 8'(b); in_idx = 4'(idx); in_c = 1'(c);
            @(negedge clk);
            check(tag_of(op, idx), pack_out(), model(op, b, idx, c));
          end
        end
      end
      // R2 / R10: idle cycle after each burst
      in_valid = 1'b0;
      @(negedge clk);
      check("R2", {13'h0, out_valid}, 14'h0);
      check("R10", pack_out(), 14'h0);
    end

    // R2: a single isolated request
    in_valid = 1'b1; in_op = 4'd0; in_byte = 8'h00; in_idx = 4'd7; in_c = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", pack_out(), {1'b1, 8'h80, 1'b1, 4'b0000});
    @(negedge clk);
    check("R2", pack_out(), 14'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule